// File: doc/BRIEF.md
# Bus Phase Status and Interrupt Register Block

This block holds the status and interrupt state of a storage bus controller core. A status byte carries the present bus phase in its three low bits, a terminal-count flag, two error flags and an interrupt-pending flag. The pending flag drives the interrupt pin directly. Next to it sit an interrupt-cause byte, a sequence-step value and a FIFO-flags view that packs the sequence step with the live FIFO byte count.

Software reaches the block over a byte-wide register port with plain read and write strobes. Read data is combinational from the address. A read's side effects take hold at the clock edge where the strobe is sampled. The neighbouring sequencer drives single-cycle strobes that set cause bits, load the phase and sequence step, and set or clear the terminal-count and error flags. The FIFO supplies its byte count as a level.

Four simple commands are decoded here: bus reset, message accept, enable selection and disable selection. All other command codes leave this block untouched. Selection sequencing and the data movers sit elsewhere.

Top module: `phase_irq_regs`

Register addresses on `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | status | read |
| 1 | cause | read, clears on read |
| 2 | sequence step | read |
| 3 | FIFO flags | read |
| 4 | configuration | read/write |
| 5 | command | write |

Any other read address returns 0.

## Requirements
- R1: A `phase_wr` strobe loads `phase_code` into status bits 2:0 and onto the `phase` output. The codes are 0 data-out, 1 data-in, 2 command, 3 status, 6 message-out and 7 message-in. Codes 4 and 5 are reserved and leave the phase unchanged.
- R2: `irq` equals status bit 7, the pending flag. The flag rises at the same clock edge where any bit is newly set in the cause byte. It then stays high until a cause read or a reset clears it, so `irq` changes only when the flag itself changes.
- R3: A read of address 1 returns the cause byte and then zeroes it and the pending flag. Cause bits set by events in the same cycle as the read are kept, and they re-raise the pending flag.
- R4: A cause read also clears the error flags (status bits 6 and 5). It keeps the phase field (bits 2:0) and the terminal-count flag (bit 4). Status bit 3 always reads 0.
- R5: A read of address 3 returns the FIFO byte count in bits 4:0 and the sequence step in bits 7:5.
- R6: Command code 0x03 (bus reset) sets cause bit 7 only when configuration bit 6 (suppress reset reporting) is 0.
- R7: Command code 0x12 (message accept) sets cause bit 5 (disconnect) and clears the sequence step, so the FIFO-flags view reads only the count. It wins over a `seq_wr` in the same cycle.
- R8: Command codes 0x44 and 0x45 (enable and disable selection) clear the cause byte. The pending flag and `irq` are left as they were.
- R9: After reset the status, cause and sequence step read 0, `irq` is 0, and the configuration register reads 0x07.
- R10: `evt_tc_set` sets status bit 4 and `evt_tc_clr` clears it; set wins when both arrive together. `evt_err[1]` sets status bit 6 and `evt_err[0]` sets bit 5. Command bit 7 (the DMA flag) is ignored when the command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; applies side effects at the edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| evt_cause | input | 8 | Cause bits to set this cycle |
| evt_tc_set | input | 1 | Set the terminal-count flag |
| evt_tc_clr | input | 1 | Clear the terminal-count flag |
| evt_err | input | 2 | Set the error flags |
| phase_wr | input | 1 | Load a new phase |
| phase_code | input | 3 | Phase to load |
| seq_wr | input | 1 | Load the sequence step |
| seq_val | input | 3 | Sequence step to load |
| fifo_count | input | 5 | FIFO byte count |
| irq | output | 1 | Interrupt request |
| phase | output | 3 | Current bus phase |
| cfg_out | output | 8 | Configuration register contents |

## Verification
The bench builds the block with its defaults: a 5-bit FIFO count, a 3-bit sequence step and a reset configuration value of 0x07. The count and the step then fill one byte exactly, so a single FIFO-flags read shows both fields at their true bit positions. Any overlap or gap between them would show up in that read. The 5-bit count also allows a count value whose top bit is set, which shows that bit 4 is not dropped.

// File: rtl/phase_irq_pkg.sv
package phase_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEQ    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd5;

  localparam logic [6:0] OP_BUSRST = 7'h03;
  localparam logic [6:0] OP_MSGACC = 7'h12;
  localparam logic [6:0] OP_SELEN  = 7'h44;
  localparam logic [6:0] OP_SELDIS = 7'h45;

  localparam int CAUSE_BUSRST = 7;
  localparam int CAUSE_DISC   = 5;
  localparam int CFG_NOREP    = 6;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0, PH_DIN = 3'd1, PH_CMD = 3'd2, PH_STAT = 3'd3,
    PH_RSV4 = 3'd4, PH_RSV5 = 3'd5, PH_MOUT = 3'd6, PH_MIN = 3'd7
  } phase_e;
endpackage

// File: rtl/pir_cause.sv
module pir_cause (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_clr,
  input  logic       cmd_clr,
  input  logic [7:0] set_bits,
  output logic [7:0] cause_q,
  output logic       pend_q
);
  logic [7:0] base;
  always_comb base = (rd_clr || cmd_clr) ? 8'h00 : cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cause_q <= base | set_bits;
      pend_q  <= (pend_q && !rd_clr) || (|set_bits);
    end
  end
endmodule

// File: rtl/pir_status.sv
module pir_status
  import phase_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_wr,
  input  logic [2:0] phase_code,
  input  logic       tc_set,
  input  logic       tc_clr,
  input  logic [1:0] err_set,
  input  logic       rd_clr,
  output logic [2:0] phase_q,
  output logic       tc_q,
  output logic [1:0] err_q
);
  logic code_ok;
  always_comb code_ok = (phase_code != PH_RSV4) && (phase_code != PH_RSV5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DOUT;
      tc_q    <= 1'b0;
      err_q   <= '0;
    end else begin
      if (phase_wr && code_ok) phase_q <= phase_code;
      if (tc_set)      tc_q <= 1'b1;
      else if (tc_clr) tc_q <= 1'b0;
      err_q <= (rd_clr ? 2'b00 : err_q) | err_set;
    end
  end
endmodule

// File: rtl/pir_readmux.sv
module pir_readmux
  import phase_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SEQ_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        status,
  input  logic [7:0]        cause,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        cfg,
  output logic [7:0]        rdata
);
  logic [7:0] flags;
  logic [7:0] seq_b;

  always_comb begin
    flags = '0;
    flags[CNT_W-1:0] = count;
    flags[CNT_W +: SEQ_W] = seq;
    seq_b = '0;
    seq_b[SEQ_W-1:0] = seq;
  end

  always_comb begin
    unique case (addr)
      A_STATUS: rdata = status;
      A_CAUSE:  rdata = cause;
      A_SEQ:    rdata = seq_b;
      A_FLAGS:  rdata = flags;
      A_CFG:    rdata = cfg;
      default:  rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/phase_irq_regs.sv
module phase_irq_regs
  import phase_irq_pkg::*;
#(
  parameter int         CNT_W     = 5,
  parameter int         SEQ_W     = 3,
  parameter logic [7:0] CFG1_INIT = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [7:0]        evt_cause,
  input  logic              evt_tc_set,
  input  logic              evt_tc_clr,
  input  logic [1:0]        evt_err,
  input  logic              phase_wr,
  input  logic [2:0]        phase_code,
  input  logic              seq_wr,
  input  logic [SEQ_W-1:0]  seq_val,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              irq,
  output logic [2:0]        phase,
  output logic [7:0]        cfg_out
);
  logic             cmd_wr, cmd_busrst, cmd_msgacc, cmd_selclr, cause_rd;
  logic [7:0]       set_bits, cause_q, status_b, cfg_q;
  logic             pend_q, tc_q;
  logic [1:0]       err_q;
  logic [2:0]       phase_q;
  logic [SEQ_W-1:0] seq_q;

  always_comb begin
    cmd_wr     = reg_wr && (reg_addr == A_CMD);
    cmd_busrst = cmd_wr && (reg_wdata[6:0] == OP_BUSRST);
    cmd_msgacc = cmd_wr && (reg_wdata[6:0] == OP_MSGACC);
    cmd_selclr = cmd_wr && ((reg_wdata[6:0] == OP_SELEN) ||
                            (reg_wdata[6:0] == OP_SELDIS));
    cause_rd   = reg_rd && (reg_addr == A_CAUSE);
    set_bits   = evt_cause;
    if (cmd_busrst && !cfg_q[CFG_NOREP]) set_bits[CAUSE_BUSRST] = 1'b1;
    if (cmd_msgacc) set_bits[CAUSE_DISC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG1_INIT;
      seq_q <= '0;
    end else begin
      if (reg_wr && (reg_addr == A_CFG)) cfg_q <= reg_wdata;
      if (cmd_msgacc)  seq_q <= '0;
      else if (seq_wr) seq_q <= seq_val;
    end
  end

  pir_cause u_cause (
    .clk(clk), .rst_n(rst_n), .rd_clr(cause_rd), .cmd_clr(cmd_selclr),
    .set_bits(set_bits), .cause_q(cause_q), .pend_q(pend_q)
  );

  pir_status u_status (
    .clk(clk), .rst_n(rst_n), .phase_wr(phase_wr), .phase_code(phase_code),
    .tc_set(evt_tc_set), .tc_clr(evt_tc_clr), .err_set(evt_err),
    .rd_clr(cause_rd), .phase_q(phase_q), .tc_q(tc_q), .err_q(err_q)
  );

  always_comb status_b = {pend_q, err_q, tc_q, 1'b0, phase_q};

  pir_readmux #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_rmux (
    .addr(reg_addr), .status(status_b), .cause(cause_q), .seq(seq_q),
    .count(fifo_count), .cfg(cfg_q), .rdata(reg_rdata)
  );

  assign irq     = pend_q;
  assign phase   = phase_q;
  assign cfg_out = cfg_q;
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int SEQ_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [7:0]       evt_cause,
  input logic             cause_rd,
  input logic             cmd_busrst,
  input logic             cmd_msgacc,
  input logic [7:0]       cause_q,
  input logic             phase_wr,
  input logic [2:0]       phase_code,
  input logic [2:0]       phase,
  input logic [SEQ_W-1:0] seq_q,
  input logic             tc_q,
  input logic             evt_tc_set,
  input logic             evt_tc_clr
);
  // R2
  evt_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_cause) |=> irq);
  // R2
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cause_rd) |=> irq);
  // R3
  cause_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && evt_cause == 8'h00 && !cmd_busrst && !cmd_msgacc)
      |=> (cause_q == 8'h00 && !irq));
  // R1
  phase_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_wr && (phase_code == 3'd4 || phase_code == 3'd5)) |=> $stable(phase));
  // R7
  msgacc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_msgacc |=> (seq_q == '0 && cause_q[5]));
  // R4
  tc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !evt_tc_set && !evt_tc_clr) |=> $stable(tc_q));
endmodule

bind phase_irq_regs pir_checker #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .evt_cause(evt_cause),
  .cause_rd(cause_rd), .cmd_busrst(cmd_busrst), .cmd_msgacc(cmd_msgacc),
  .cause_q(cause_q), .phase_wr(phase_wr), .phase_code(phase_code),
  .phase(phase), .seq_q(seq_q), .tc_q(tc_q), .evt_tc_set(evt_tc_set),
  .evt_tc_clr(evt_tc_clr)
);

// File: tb/phase_irq_regs_bench.sv
module phase_irq_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] evt_cause = '0;
  logic       evt_tc_set = 1'b0, evt_tc_clr = 1'b0;
  logic [1:0] evt_err = '0;
  logic       phase_wr = 1'b0;
  logic [2:0] phase_code = '0;
  logic       seq_wr = 1'b0;
  logic [2:0] seq_val = '0;
  logic [4:0] fifo_count = '0;
  logic       irq;
  logic [2:0] phase;
  logic [7:0] cfg_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phase_irq_regs u_phase_irq_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_cause(evt_cause), .evt_tc_set(evt_tc_set), .evt_tc_clr(evt_tc_clr),
    .evt_err(evt_err), .phase_wr(phase_wr), .phase_code(phase_code),
    .seq_wr(seq_wr), .seq_val(seq_val), .fifo_count(fifo_count),
    .irq(irq), .phase(phase), .cfg_out(cfg_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] c, input logic [1:0] e, input logic ts);
    @(negedge clk);
    evt_cause = c; evt_err = e; evt_tc_set = ts;
    @(negedge clk);
    evt_cause = '0; evt_err = '0; evt_tc_set = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R9 irq after reset", {7'd0, irq}, 8'h00);
    rd(3'd0, v); chk("R9 status reset", v, 8'h00);
    rd(3'd2, v); chk("R9 seq reset", v, 8'h00);
    rd(3'd4, v); chk("R9 cfg reset", v, 8'h07);
    rd(3'd1, v); chk("R9 cause reset", v, 8'h00);
  endtask

  task automatic t_phase();
    logic [7:0] v;
    logic [2:0] codes [5] = '{3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); phase_wr = 1'b1; phase_code = codes[i];
      @(negedge clk); phase_wr = 1'b0;
      rd(3'd0, v); chk("R1 phase load", v, {5'd0, codes[i]});
    end
    @(negedge clk); phase_wr = 1'b1; phase_code = 3'd4;
    @(negedge clk); phase_code = 3'd5;
    @(negedge clk); phase_wr = 1'b0;
    chk("R1 reserved ignored", {5'd0, phase}, 8'h07);
  endtask

  task automatic t_event_read();
    logic [7:0] v;
    pulse_evt(8'h10, 2'b11, 1'b1);
    chk("R2 irq raised", {7'd0, irq}, 8'h01);
    rd(3'd0, v); chk("R4 status before read", v, 8'hF7);
    rd(3'd1, v); chk("R3 cause value", v, 8'h10);
    chk("R2 irq lowered", {7'd0, irq}, 8'h00);
    rd(3'd0, v); chk("R4 status keeps phase and tc", v, 8'h17);
    rd(3'd1, v); chk("R3 cause zeroed", v, 8'h00);
    @(negedge clk); evt_tc_clr = 1'b1;
    @(negedge clk); evt_tc_clr = 1'b0;
    rd(3'd0, v); chk("R10 tc cleared", v, 8'h07);
    @(negedge clk); evt_tc_clr = 1'b1; evt_tc_set = 1'b1;
    @(negedge clk); evt_tc_clr = 1'b0; evt_tc_set = 1'b0;
    rd(3'd0, v); chk("R10 tc set wins", v, 8'h17);
  endtask

  task automatic t_overlap();
    logic [7:0] v;
    pulse_evt(8'h08, 2'b00, 1'b0);
    @(negedge clk);
    reg_addr = 3'd1; reg_rd = 1'b1; evt_cause = 8'h04;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; evt_cause = '0;
    chk("R3 overlap read value", v, 8'h08);
    chk("R3 overlap irq kept", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R3 overlap event kept", v, 8'h04);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    @(negedge clk); seq_wr = 1'b1; seq_val = 3'd5; fifo_count = 5'h13;
    @(negedge clk); seq_wr = 1'b0;
    rd(3'd3, v); chk("R5 flags view", v, 8'hB3);
    rd(3'd2, v); chk("R5 seq read", v, 8'h05);
  endtask

  task automatic t_msgacc();
    logic [7:0] v;
    @(negedge clk);
    reg_addr = 3'd5; reg_wdata = 8'h92; reg_wr = 1'b1;
    seq_wr = 1'b1; seq_val = 3'd6;
    @(negedge clk); reg_wr = 1'b0; seq_wr = 1'b0;
    chk("R7 irq on accept", {7'd0, irq}, 8'h01);
    rd(3'd3, v); chk("R7 flags seq cleared", v, 8'h13);
    rd(3'd1, v); chk("R7 disconnect cause (R10 dma bit)", v, 8'h20);
  endtask

  task automatic t_busreset();
    logic [7:0] v;
    wr(3'd5, 8'h03);
    chk("R6 reported irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R6 reported cause", v, 8'h80);
    wr(3'd4, 8'h47);
    rd(3'd4, v); chk("R6 cfg written", v, 8'h47);
    wr(3'd5, 8'h03);
    chk("R6 suppressed irq", {7'd0, irq}, 8'h00);
    rd(3'd1, v); chk("R6 suppressed cause", v, 8'h00);
    wr(3'd4, 8'h07);
  endtask

  task automatic t_selclr();
    logic [7:0] v;
    logic [7:0] ops [2] = '{8'h44, 8'hC5};
    for (int i = 0; i < 2; i++) begin
      pulse_evt(8'h09, 2'b00, 1'b0);
      wr(3'd5, ops[i]);
      chk("R8 pending kept", {7'd0, irq}, 8'h01);
      rd(3'd1, v); chk("R8 cause cleared", v, 8'h00);
      chk("R8 read drops pending", {7'd0, irq}, 8'h00);
    end
    pulse_evt(8'h02, 2'b00, 1'b0);
    wr(3'd5, 8'h01);
    rd(3'd1, v); chk("R8 other command no effect", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_phase();
    t_event_read();
    t_overlap();
    t_flags();
    t_msgacc();
    t_busreset();
    t_selclr();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule